// File: doc/BRIEF.md
# Buffered SPI Flash Host Controller

This block is a register-mapped SPI master for talking to a serial flash device. Software writes a command opcode into a dedicated register, writes a byte-count register giving how many bytes to send after the opcode and how many to receive, and pushes the outgoing payload through a single data port into a small circular byte buffer. Setting the start bit then runs one complete chip-select framed exchange in SPI mode 0.

The same buffer holds the outgoing payload and the received response. A 3-bit buffer pointer steps once for every data-port access and once for every payload byte the engine takes or stores. Software can read the pointer in the status byte at any time and can zero it through the control register. A typical sequence is: clear the pointer, load the payload, check that the pointer equals the payload length, clear it again, start, wait for the start bit to fall, clear it, read past the echoed payload, then read the response bytes. At each stage the pointer value confirms that no other agent has disturbed the buffer.

The SPI clock rate is picked by a 2-bit rate input that the status byte also reports. Each code sets a half-period of the serial clock counted in system clocks.

Top module: `spi_fifo_host`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0 and mosi is 0. The opcode, count and control registers read 0x00, the pointer is 0, and all eight buffer slots read 0x00.
- R2: The opcode register (offset 0x0) and the count register (offset 0x1) read back the last value written. The count register keeps its programmed value through a transfer. Count bits 3:0 are the number of bytes sent after the opcode, and bits 7:4 are the number of bytes received.
- R3: A write to the data port (offset 0xC) stores the byte in the slot the pointer selects, and the pointer then steps by one modulo 8. A read of the data port returns the selected slot and also steps the pointer. After N bytes are loaded from pointer 0, the pointer reads N mod 8.
- R4: In the control register (offset 0x2), writing 1 to bit 4 sets the pointer to 0, and bit 4 always reads 0. Bits 7:5 and 3:1 read back the last value written to them.
- R5: The status byte (offset 0xD) shows the pointer in bits 2:0 and the rate input in bits 5:4. Bits 7:6 and bit 3 read 0.
- R6: Writing 1 to control bit 0 while idle starts a transfer. Bit 0 reads 1 while the transfer runs and returns to 0 in the same cycle that cs_n returns high.
- R7: During a transfer, cs_n stays low while the controller sends the opcode, then W bytes taken from consecutive buffer slots starting at the pointer, then clocks in R bytes. There are exactly 8*(1+W+R) rising sclk edges. No extra receive byte is added when W is 0.
- R8: The serial format is mode 0. sclk idles low. mosi is driven MSB first and changes only while sclk is low. miso is sampled on the rising edge of sclk. mosi is 0 during received bytes.
- R9: Received bytes go into the slots that follow the sent bytes, in arrival order. Sent-byte slots keep their contents. After a transfer started from pointer P, the pointer reads (P+W+R) mod 8.
- R10: With rate codes 01, 10 and 11, sclk stays high for 2, 3 and 4 system clocks respectively, and low for the same time. The reserved code 00 runs at the code-11 rate.
- R11: While a transfer runs, every register write is ignored: data, opcode, count, pointer clear and start. Data-port reads do not step the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, valid while bus_rd is high |
| rate_sel | input | 2 | SPI clock rate code |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data to the flash |
| miso | input | 1 | SPI data from the flash |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bound checker watches, on every cycle, the relations between the serial pins and the internal state. It checks that sclk stays low while chip select is high and that mosi holds steady while sclk is high. It checks that every high sclk phase lasts a legal number of clocks, that the count register cannot change during a transfer, and that the pointer only holds, steps by one or returns to zero. Other properties need a scripted flash model and an arithmetic model of the buffer, so only the bench scenarios can show them. These are the exact byte stream on mosi, where the received bytes land in the shared buffer, the final pointer value for each write/read count pair, the per-code sclk width, and that writes issued mid-transfer leave no trace.

// File: rtl/spi_fifo_pkg.sv
// Package: shared register offsets, sequencer phase type and rate helper
// for the buffered SPI flash host. Assumes an 8-bit register bus.
package spi_fifo_pkg;

    localparam logic [3:0] ADR_OPCODE = 4'h0;
    localparam logic [3:0] ADR_COUNT  = 4'h1;
    localparam logic [3:0] ADR_CTRL   = 4'h2;
    localparam logic [3:0] ADR_DATA   = 4'hC;
    localparam logic [3:0] ADR_STAT   = 4'hD;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_CLEAR_BIT = 4;

    // Kind of byte currently on the wire
    typedef enum logic [1:0] {
        PH_OPC = 2'd0,
        PH_WR  = 2'd1,
        PH_RD  = 2'd2
    } phase_e;

    // Half-period of sclk in system clocks for a rate code; code 0 is slowest.
    function automatic int half_clocks(input logic [1:0] code, input int unit);
        if (code == 2'b00)
            return 4 * unit;
        return (int'(code) + 1) * unit;
    endfunction

endpackage

// File: rtl/spi_fifo_buf.sv
// Module: circular byte buffer with one shared pointer.
// The slot under the pointer is always visible on rd_data. A write stores
// into that slot; a step moves the pointer by one, wrapping at DEPTH.
// Assumes DEPTH is a power of two and that clear has priority over step.
module spi_fifo_buf #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    output logic [DATA_W-1:0] rd_data,
    output logic [PTR_W-1:0]  ptr
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  ptr_q;

    // Slot storage: zeroed on reset, written at the pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '0;
        end else if (we) begin
            mem_q[ptr_q] <= wdata;
        end
    end

    // Pointer: clear wins, otherwise advance modulo DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (clr)
            ptr_q <= '0;
        else if (step)
            ptr_q <= ptr_q + 1'b1;
    end

    assign rd_data = mem_q[ptr_q];
    assign ptr     = ptr_q;

endmodule

// File: rtl/spi_shift_eng.sv
// Module: SPI mode-0 byte shifter with built-in clock divider.
// Runs back-to-back bytes while `more` is high at each byte boundary.
// mosi changes on sclk falling edges (or at go), miso is sampled on rising
// edges, MSB first. Assumes half_len >= 2 and stable while active.
module spi_shift_eng #(
    parameter int HALF_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [7:0]        first_byte,
    input  logic [HALF_W-1:0] half_len,
    input  logic              more,
    input  logic [7:0]        next_byte,
    input  logic              miso,
    output logic              active,
    output logic              sclk,
    output logic              mosi,
    output logic              byte_end,
    output logic [7:0]        rx_byte
);

    logic              active_q;
    logic              sclk_q;
    logic              mosi_q;
    logic [2:0]        bit_q;
    logic [7:0]        tx_q;
    logic [7:0]        rx_q;
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] half_q;
    logic              tick;

    assign tick     = active_q && (cnt_q == half_q - 1'b1);
    assign byte_end = tick && sclk_q && (bit_q == 3'd7);

    // Divider, edge generation and bit shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            mosi_q   <= 1'b0;
            bit_q    <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            cnt_q    <= '0;
            half_q   <= '0;
        end else if (!active_q) begin
            if (go) begin
                active_q <= 1'b1;
                half_q   <= half_len;
                tx_q     <= first_byte;
                mosi_q   <= first_byte[7];
                bit_q    <= '0;
                cnt_q    <= '0;
                sclk_q   <= 1'b0;
            end
        end else if (tick) begin
            cnt_q <= '0;
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                rx_q   <= {rx_q[6:0], miso};
            end else begin
                sclk_q <= 1'b0;
                if (bit_q != 3'd7) begin
                    bit_q  <= bit_q + 1'b1;
                    tx_q   <= {tx_q[6:0], 1'b0};
                    mosi_q <= tx_q[6];
                end else if (more) begin
                    bit_q  <= '0;
                    tx_q   <= next_byte;
                    mosi_q <= next_byte[7];
                end else begin
                    active_q <= 1'b0;
                    mosi_q   <= 1'b0;
                end
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign active  = active_q;
    assign sclk    = sclk_q;
    assign mosi    = mosi_q;
    assign rx_byte = rx_q;

endmodule

// File: rtl/spi_fifo_seq.sv
// Module: transfer sequencer. Tracks whether the byte on the wire is the
// opcode, a sent payload byte or a received byte, decides the next byte at
// each byte boundary, fetches sent bytes from the buffer and stores
// received bytes into it. Assumes byte_end is a one-cycle pulse.
module spi_fifo_seq
    import spi_fifo_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] wcnt,
    input  logic [CNT_W-1:0] rcnt,
    input  logic             byte_end,
    input  logic [7:0]       rx_byte,
    input  logic [7:0]       buf_rd,
    output logic             more,
    output logic [7:0]       next_byte,
    output logic             buf_step,
    output logic             buf_we,
    output logic [7:0]       buf_wdata
);

    phase_e           phase_q, nxt_phase;
    logic [CNT_W-1:0] left_q, nxt_left;

    // Next-byte decision from the current phase and remaining counts
    always_comb begin
        nxt_phase = PH_RD;
        nxt_left  = '0;
        more      = 1'b0;
        unique case (phase_q)
            PH_OPC: begin
                if (wcnt != '0) begin
                    nxt_phase = PH_WR; nxt_left = wcnt; more = 1'b1;
                end else if (rcnt != '0) begin
                    nxt_phase = PH_RD; nxt_left = rcnt; more = 1'b1;
                end
            end
            PH_WR: begin
                if (left_q > 1) begin
                    nxt_phase = PH_WR; nxt_left = left_q - 1'b1; more = 1'b1;
                end else if (rcnt != '0) begin
                    nxt_phase = PH_RD; nxt_left = rcnt; more = 1'b1;
                end
            end
            default: begin
                if (left_q > 1) begin
                    nxt_phase = PH_RD; nxt_left = left_q - 1'b1; more = 1'b1;
                end
            end
        endcase
    end

    assign next_byte = (nxt_phase == PH_WR) ? buf_rd : 8'h00;
    assign buf_we    = byte_end && (phase_q == PH_RD);
    assign buf_wdata = rx_byte;
    assign buf_step  = byte_end && ((phase_q == PH_RD) || (more && nxt_phase == PH_WR));

    // Phase and remaining-byte bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_OPC;
            left_q  <= '0;
        end else if (go) begin
            phase_q <= PH_OPC;
            left_q  <= '0;
        end else if (byte_end && more) begin
            phase_q <= nxt_phase;
            left_q  <= nxt_left;
        end
    end

endmodule

// File: rtl/spi_fifo_host.sv
// Module: top of the buffered SPI flash host. Holds the opcode, count and
// control registers, decodes the register bus, muxes buffer access between
// software and the transfer engine, and derives the sclk half-period from
// the rate code. Assumes at most one of bus_wr/bus_rd targets the data
// port per cycle is meaningful; both together step the pointer once.
module spi_fifo_host
    import spi_fifo_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DEPTH    = 8,
    parameter int CNT_W    = 4,
    parameter int DIV_UNIT = 1,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int HALF_W  = $clog2(4 * DIV_UNIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [1:0]        rate_sel,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);

    logic [7:0]         op_q;
    logic [2*CNT_W-1:0] cnt_q;
    logic [5:0]         spare_q;
    logic               xfer_busy;
    logic               wr_ok, data_hit, go, buf_clr;
    logic [PTR_W-1:0]   buf_ptr;
    logic [7:0]         buf_rd;
    logic               bus_we, bus_step;
    logic               seq_we, seq_step, more, byte_end;
    logic [7:0]         seq_wdata, next_byte, rx_byte;
    logic [HALF_W-1:0]  half_len;

    assign wr_ok    = bus_wr && !xfer_busy;
    assign data_hit = (bus_addr == ADDR_W'(ADR_DATA)) && !xfer_busy;
    assign go       = wr_ok && (bus_addr == ADDR_W'(ADR_CTRL)) && bus_wdata[CTRL_START_BIT];
    assign buf_clr  = wr_ok && (bus_addr == ADDR_W'(ADR_CTRL)) && bus_wdata[CTRL_CLEAR_BIT];
    assign bus_we   = bus_wr && data_hit;
    assign bus_step = (bus_wr || bus_rd) && data_hit;
    assign half_len = HALF_W'(half_clocks(rate_sel, DIV_UNIT));

    // Software-visible registers, frozen while a transfer runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            cnt_q   <= '0;
            spare_q <= '0;
        end else if (wr_ok) begin
            if (bus_addr == ADDR_W'(ADR_OPCODE)) op_q  <= bus_wdata;
            if (bus_addr == ADDR_W'(ADR_COUNT))  cnt_q <= bus_wdata[2*CNT_W-1:0];
            if (bus_addr == ADDR_W'(ADR_CTRL))
                spare_q <= {bus_wdata[7:5], bus_wdata[3:1]};
        end
    end

    // Read data mux
    always_comb begin
        bus_rdata = 8'h00;
        case (bus_addr)
            ADDR_W'(ADR_OPCODE): bus_rdata = op_q;
            ADDR_W'(ADR_COUNT):  bus_rdata = 8'(cnt_q);
            ADDR_W'(ADR_CTRL):   bus_rdata = {spare_q[5:3], 1'b0, spare_q[2:0], xfer_busy};
            ADDR_W'(ADR_DATA):   bus_rdata = buf_rd;
            ADDR_W'(ADR_STAT):   bus_rdata = {2'b00, rate_sel, 1'b0, 3'(buf_ptr)};
            default:             bus_rdata = 8'h00;
        endcase
    end

    spi_fifo_buf #(.DEPTH(DEPTH), .DATA_W(8)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .we      (bus_we || seq_we),
        .wdata   (xfer_busy ? seq_wdata : bus_wdata),
        .step    (bus_step || seq_step),
        .rd_data (buf_rd),
        .ptr     (buf_ptr)
    );

    spi_fifo_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .wcnt      (cnt_q[CNT_W-1:0]),
        .rcnt      (cnt_q[2*CNT_W-1:CNT_W]),
        .byte_end  (byte_end),
        .rx_byte   (rx_byte),
        .buf_rd    (buf_rd),
        .more      (more),
        .next_byte (next_byte),
        .buf_step  (seq_step),
        .buf_we    (seq_we),
        .buf_wdata (seq_wdata)
    );

    spi_shift_eng #(.HALF_W(HALF_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .first_byte (op_q),
        .half_len   (half_len),
        .more       (more),
        .next_byte  (next_byte),
        .miso       (miso),
        .active     (xfer_busy),
        .sclk       (sclk),
        .mosi       (mosi),
        .byte_end   (byte_end),
        .rx_byte    (rx_byte)
    );

    assign cs_n = !xfer_busy;

endmodule

// File: rtl/spi_fifo_host_chk.sv
// Module: property checker for spi_fifo_host, attached with bind below.
// Watches serial pins and internal busy/pointer/count state each cycle.
module spi_fifo_host_chk #(
    parameter int PTR_W    = 3,
    parameter int CNT_BITS = 8,
    parameter int DIV_UNIT = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                sclk,
    input logic                mosi,
    input logic                busy,
    input logic [PTR_W-1:0]    ptr,
    input logic [CNT_BITS-1:0] cnt
);

    logic       armed;
    logic [7:0] hi_cnt;

    // One cycle of history since reset before $past-based checks apply
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Length of the current high sclk phase in clocks
    always_ff @(posedge clk) begin
        if (!rst_n)    hi_cnt <= '0;
        else if (sclk) hi_cnt <= hi_cnt + 1'b1;
        else           hi_cnt <= '0;
    end

    // R8
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R8
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R10
    sclk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $fell(sclk) |-> (hi_cnt >= 8'(2 * DIV_UNIT) && hi_cnt <= 8'(4 * DIV_UNIT)));

    // R2
    count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (busy && $past(busy)) |-> $stable(cnt));

    // R9
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (ptr == $past(ptr)) || (ptr == PTR_W'($past(ptr) + 1'b1)) || (ptr == '0));

endmodule

bind spi_fifo_host spi_fifo_host_chk #(
    .PTR_W    (PTR_W),
    .CNT_BITS (2 * CNT_W),
    .DIV_UNIT (DIV_UNIT)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .mosi  (mosi),
    .busy  (xfer_busy),
    .ptr   (buf_ptr),
    .cnt   (cnt_q)
);

// File: tb/spi_fifo_host_test.sv
`timescale 1ns/1ps
// Bench: sweeps all write/read count pairs 0..7 against a scripted flash
// model and an arithmetic model of the shared buffer.
module spi_fifo_host_test;

    localparam logic [3:0] A_OPC  = 4'h0;
    localparam logic [3:0] A_CNT  = 4'h1;
    localparam logic [3:0] A_CTRL = 4'h2;
    localparam logic [3:0] A_DATA = 4'hC;
    localparam logic [3:0] A_STAT = 4'hD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] rdat;
    logic [1:0] rate = 2'b01;
    logic       sclk, mosi, cs_n;
    logic       miso = 1'b0;

    int checks = 0;
    int fails  = 0;

    // flash model state
    logic [7:0] seed = '0;
    int         sbits = 0;
    int         rises = 0;
    int         hi_run = 0;
    int         hi_last = 0;
    logic       sclk_p = 1'b0;
    logic [7:0] cap [0:31];
    logic [7:0] m [0:7];
    logic [7:0] wbytes [0:15];

    spi_fifo_host uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wd), .bus_rdata(rdat), .rate_sel(rate),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] resp(input int k);
        return 8'h3C ^ 8'(k * 29) ^ seed;
    endfunction

    function automatic int half_of(input int code);
        return (code == 0) ? 4 : code + 1;
    endfunction

    // Flash model, evaluated between clock edges
    always @(negedge clk) begin
        logic [7:0] t;
        if (cs_n) begin
            sbits = 0;
            t = resp(0);
            miso = t[7];
        end else begin
            if (sclk && !sclk_p) begin
                rises++;
                cap[sbits / 8] = {cap[sbits / 8][6:0], mosi};
            end
            if (!sclk && sclk_p) begin
                hi_last = hi_run;
                sbits++;
                t = resp(sbits / 8);
                miso = t[7 - (sbits % 8)];
            end
        end
        hi_run = sclk ? hi_run + 1 : 0;
        sclk_p = sclk;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wd = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic br(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdat;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wait_idle();
        wait (cs_n === 1'b1);
        @(negedge clk);
    endtask

    task automatic run_txn(input int w, input int r, input int code);
        logic [7:0] v;
        logic [7:0] opc;
        rate = 2'(code);
        seed = 8'(w * 16 + r);
        opc  = 8'(8'h90 + w + r);
        bw(A_CTRL, 8'h10);
        for (int i = 0; i < w; i++) begin
            wbytes[i] = 8'(8'h51 + 17 * i + 3 * w);
            m[i % 8] = wbytes[i];
            bw(A_DATA, wbytes[i]);
        end
        br(A_STAT, v);
        chk("R3 pointer after load", int'(v[2:0]), w % 8);
        bw(A_OPC, opc);
        bw(A_CNT, {4'(r), 4'(w)});
        bw(A_CTRL, 8'h10);
        rises = 0;
        bw(A_CTRL, 8'h01);
        br(A_CTRL, v);
        chk("R6 start reads busy", int'(v[0]), 1);
        wait_idle();
        br(A_CTRL, v);
        chk("R6 start self-clears", int'(v[0]), 0);
        chk("R7 sclk rising edges", rises, 8 * (1 + w + r));
        chk("R10 sclk high width", hi_last, half_of(code));
        chk("R7 opcode on mosi", int'(cap[0]), int'(opc));
        for (int i = 0; i < w; i++)
            chk("R7 payload on mosi", int'(cap[1 + i]), int'(wbytes[i]));
        for (int i = 0; i < r; i++)
            chk("R8 mosi low while receiving", int'(cap[1 + w + i]), 0);
        br(A_STAT, v);
        chk("R9 pointer after transfer", int'(v[2:0]), (w + r) % 8);
        br(A_CNT, v);
        chk("R2 count kept", int'(v), r * 16 + w);
        br(A_OPC, v);
        chk("R2 opcode kept", int'(v), int'(opc));
        for (int i = 0; i < r; i++)
            m[(w + i) % 8] = resp(1 + w + i);
        bw(A_CTRL, 8'h10);
        for (int i = 0; i < 8; i++) begin
            br(A_DATA, v);
            chk("R9 buffer slot", int'(v), int'(m[i]));
        end
        br(A_STAT, v);
        chk("R3 pointer wraps after 8 reads", int'(v[2:0]), 0);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 32; i++) cap[i] = '0;
        for (int i = 0; i < 8; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cs_n idle", int'(cs_n), 1);
        chk("R1 sclk idle", int'(sclk), 0);
        chk("R1 mosi idle", int'(mosi), 0);
        br(A_OPC, v);  chk("R1 opcode reset", int'(v), 0);
        br(A_CNT, v);  chk("R1 count reset", int'(v), 0);
        br(A_CTRL, v); chk("R1 control reset", int'(v), 0);
        br(A_STAT, v); chk("R1 pointer reset", int'(v[2:0]), 0);
        for (int i = 0; i < 8; i++) begin
            br(A_DATA, v);
            chk("R1 buffer slot reset", int'(v), 0);
        end

        // R4 control spare bits and pointer clear
        bw(A_CTRL, 8'hEE);
        br(A_CTRL, v); chk("R4 spare bits read back", int'(v), 8'hEE);
        bw(A_DATA, 8'h11);
        bw(A_DATA, 8'h22);
        br(A_STAT, v); chk("R3 pointer after two writes", int'(v[2:0]), 2);
        bw(A_CTRL, 8'h10);
        br(A_CTRL, v); chk("R4 clear bit reads zero", int'(v), 0);
        br(A_STAT, v); chk("R4 pointer cleared", int'(v[2:0]), 0);
        br(A_DATA, v); chk("R3 data port read", int'(v), 8'h11);
        br(A_DATA, v); chk("R3 data port read", int'(v), 8'h22);

        // R5 status layout for every rate code
        for (int c = 0; c < 4; c++) begin
            rate = 2'(c);
            br(A_STAT, v);
            chk("R5 status byte", int'(v), (c << 4) | 2);
        end

        // R2 plain register readback
        bw(A_OPC, 8'hA7);
        br(A_OPC, v); chk("R2 opcode readback", int'(v), 8'hA7);
        bw(A_CNT, 8'h5B);
        br(A_CNT, v); chk("R2 count readback", int'(v), 8'h5B);

        for (int i = 0; i < 8; i++) m[i] = '0;
        m[0] = 8'h11; m[1] = 8'h22;

        // R7 R9 R10 sweep over all count pairs
        for (int w = 0; w < 8; w++)
            for (int r = 0; r < 8; r++)
                run_txn(w, r, (w + r) % 4);

        // R11 writes and reads during a transfer
        rate = 2'b11;
        seed = 8'hC3;
        bw(A_CTRL, 8'h10);
        bw(A_DATA, 8'hA1); m[0] = 8'hA1;
        bw(A_DATA, 8'hA2); m[1] = 8'hA2;
        bw(A_OPC, 8'h0B);
        bw(A_CNT, 8'h32);
        bw(A_CTRL, 8'h10);
        rises = 0;
        bw(A_CTRL, 8'h01);
        bw(A_DATA, 8'hEE);
        br(A_DATA, v);
        bw(A_CNT, 8'h77);
        bw(A_OPC, 8'h00);
        bw(A_CTRL, 8'h10);
        bw(A_CTRL, 8'h01);
        wait_idle();
        repeat (4) @(negedge clk);
        chk("R11 no restart after end", int'(cs_n), 1);
        chk("R11 single transfer length", rises, 48);
        br(A_STAT, v); chk("R11 pointer untouched by bus", int'(v[2:0]), 5);
        br(A_CNT, v);  chk("R11 count write ignored", int'(v), 8'h32);
        br(A_OPC, v);  chk("R11 opcode write ignored", int'(v), 8'h0B);
        for (int i = 0; i < 3; i++) m[2 + i] = resp(3 + i);
        bw(A_CTRL, 8'h10);
        for (int i = 0; i < 8; i++) begin
            br(A_DATA, v);
            chk("R11 buffer after busy writes", int'(v), int'(m[i]));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule